// File: doc/BRIEF.md
# Serial Bitwise Logic Processor

This block holds two small shift registers, A and B, and combines them one bit pair per clock using one of eight bitwise logic functions. A single execute request makes the sequencer shift both registers a fixed number of times (the register width, four by default). On each shift the least significant bits of A and B are combined. The resulting bit, or one of the original bits, enters each register at its most significant end. After a full run, each register holds the per-bit outcome chosen by the routing select.

Software or a test controller loads A and B in parallel, sets the function and routing selects, and raises the execute strobe. The sequencer has two states and decides whether to shift from both its state and the execute input. It runs once for each assertion of execute and then waits for execute to drop before it accepts another request. The eight functions come from a four-way base selection followed by an optional inversion.

Top module: `serial_logic_proc`

## Requirements
- R1: Reset (synchronous, active high) clears both registers to zero and leaves the sequencer idle.
- R2: On a clock edge where no shift happens, a high `load_a` copies `din_a` into A and a high `load_b` copies `din_b` into B, each independently.
- R3: An edge that samples `exec_req` high while the sequencer is idle performs the first shift. Exactly WIDTH shifts in total follow, on consecutive edges.
- R4: After the WIDTH-th shift the registers stay unchanged while `exec_req` remains high. Once it has been low for one edge, a new high `exec_req` starts another run.
- R5: The bit computed from a pair (a, b) is the base function selected by `func_sel[1:0]`, then XORed with `func_sel[2]`. The base functions are 00 = a AND b, 01 = a OR b, 10 = a XOR b, and 11 = constant 1.
- R6: `route_sel` sets the bits that enter the registers. 00 returns each register's own bit, so the registers are unchanged after a run. 01 sends the result to A while B keeps its own bit. 10 sends the result to B while A keeps its own bit. 11 swaps the bits between A and B, so the registers are exchanged after a run.
- R7: Load requests on any shifting edge, including the edge that starts a run, have no effect.
- R8: Each shift moves a register right by one. Bit 0 is the bit consumed, and the incoming bit enters at bit WIDTH-1. After k shifts, the low WIDTH-k bits hold the original bits k and above.
- R9: Loads take effect while the sequencer is holding after a completed run with `exec_req` still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_req | input | 1 | Execute request, level sampled |
| func_sel | input | 3 | Function select: bit 2 inverts, bits 1:0 choose the base function |
| route_sel | input | 2 | Selects which bits are shifted back into A and B |
| load_a | input | 1 | Parallel load of A |
| load_b | input | 1 | Parallel load of B |
| din_a | input | WIDTH | Parallel data for A |
| din_b | input | WIDTH | Parallel data for B |
| reg_a | output | WIDTH | Contents of register A |
| reg_b | output | WIDTH | Contents of register B |

## Verification
The hardest case to reach is a load request that arrives while a run is in flight. This includes a load on the very edge that samples the execute request, where the idle state would otherwise accept it. The stimulus holds both load strobes high with random data from the start edge through the last shift. It checks that the final contents reflect only the computed run. A directed case does the reverse: it loads while execute is still held after a run and expects the load to take effect. Random function, routing and data mixes then cover the eight functions and four routes against a bench model of the shift order.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } slp_state_e;

  typedef enum logic [1:0] {
    RT_KEEP  = 2'b00,
    RT_RES_A = 2'b01,
    RT_RES_B = 2'b10,
    RT_SWAP  = 2'b11
  } slp_route_e;

  // base function on low select bits, optional inversion on the top bit
  function automatic logic slp_eval(input logic [2:0] sel, input logic a, input logic b);
    logic base;
    case (sel[1:0])
      2'b00:   base = a & b;
      2'b01:   base = a | b;
      2'b10:   base = a ^ b;
      default: base = 1'b1;
    endcase
    return base ^ sel[2];
  endfunction

endpackage

// File: rtl/slp_seq.sv
module slp_seq
  import slp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic exec_req,
  output logic shift_en
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH);

  slp_state_e     st;
  logic [CW-1:0]  cnt;

  // Mealy output: in idle the shift follows the request directly
  always_comb begin
    shift_en = ((st == ST_IDLE) && exec_req) ||
               ((st == ST_ACTIVE) && (cnt != LAST));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (exec_req) begin
            st  <= ST_ACTIVE;
            cnt <= CW'(1);
          end
        end
        default: begin
          if (cnt != LAST) begin
            cnt <= cnt + CW'(1);
          end else if (!exec_req) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end
        end
      endcase
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  assert_start_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && exec_req) |=> (st == ST_ACTIVE && cnt == CW'(1)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACTIVE && cnt == LAST && exec_req) |=> (st == ST_ACTIVE && cnt == LAST && !shift_en));

  assert_release_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACTIVE && cnt == LAST && !exec_req) |=> (st == ST_IDLE));

endmodule

// File: rtl/slp_shreg.sv
module slp_shreg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift,
  input  logic             in_bit,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);

  // shifting has priority; a load on a shifting edge is dropped
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (shift) begin
      q <= {in_bit, q[WIDTH-1:1]};
    end else if (load) begin
      q <= din;
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!shift && !load) |=> $stable(q));

  assert_shift_right_R8: assert property (@(posedge clk) disable iff (rst)
    shift |=> (q[WIDTH-2:0] == $past(q[WIDTH-1:1]) && q[WIDTH-1] == $past(in_bit)));

endmodule

// File: rtl/serial_logic_proc.sv
module serial_logic_proc
  import slp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             exec_req,
  input  logic [2:0]       func_sel,
  input  logic [1:0]       route_sel,
  input  logic             load_a,
  input  logic             load_b,
  input  logic [WIDTH-1:0] din_a,
  input  logic [WIDTH-1:0] din_b,
  output logic [WIDTH-1:0] reg_a,
  output logic [WIDTH-1:0] reg_b
);

  localparam int NREG = 2;

  logic             shift_en;
  logic             res_bit;
  logic             in_bits [NREG];
  logic             ld      [NREG];
  logic [WIDTH-1:0] dat     [NREG];
  logic [WIDTH-1:0] q       [NREG];

  slp_seq #(.WIDTH(WIDTH)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .exec_req (exec_req),
    .shift_en (shift_en)
  );

  always_comb begin
    res_bit = slp_eval(func_sel, q[0][0], q[1][0]);
    case (route_sel)
      RT_KEEP:  begin in_bits[0] = q[0][0]; in_bits[1] = q[1][0]; end
      RT_RES_A: begin in_bits[0] = res_bit; in_bits[1] = q[1][0]; end
      RT_RES_B: begin in_bits[0] = q[0][0]; in_bits[1] = res_bit; end
      default:  begin in_bits[0] = q[1][0]; in_bits[1] = q[0][0]; end
    endcase
  end

  assign ld[0]  = load_a;
  assign ld[1]  = load_b;
  assign dat[0] = din_a;
  assign dat[1] = din_b;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    slp_shreg #(.WIDTH(WIDTH)) u_shreg (
      .clk    (clk),
      .rst    (rst),
      .shift  (shift_en),
      .in_bit (in_bits[g]),
      .load   (ld[g]),
      .din    (dat[g]),
      .q      (q[g])
    );
  end

  assign reg_a = q[0];
  assign reg_b = q[1];

  assert_load_blocked_a_R7: assert property (@(posedge clk) disable iff (rst)
    (shift_en && load_a) |=> (reg_a[WIDTH-2:0] == $past(reg_a[WIDTH-1:1])));

  assert_load_blocked_b_R7: assert property (@(posedge clk) disable iff (rst)
    (shift_en && load_b) |=> (reg_b[WIDTH-2:0] == $past(reg_b[WIDTH-1:1])));

  assert_route_keep_R6: assert property (@(posedge clk) disable iff (rst)
    (shift_en && route_sel == RT_KEEP) |=> (reg_a[WIDTH-1] == $past(reg_a[0]) && reg_b[WIDTH-1] == $past(reg_b[0])));

  assert_func_res_R5: assert property (@(posedge clk) disable iff (rst)
    (shift_en && route_sel == RT_RES_A && func_sel == 3'b111) |=> (reg_a[WIDTH-1] == 1'b0));

endmodule

// File: tb/serial_logic_proc_tb.sv
module serial_logic_proc_tb;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic         exec_req;
  logic [2:0]   func_sel;
  logic [1:0]   route_sel;
  logic         load_a, load_b;
  logic [W-1:0] din_a, din_b;
  logic [W-1:0] reg_a, reg_b;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  always #2 clk = ~clk;

  serial_logic_proc #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .exec_req(exec_req), .func_sel(func_sel),
    .route_sel(route_sel), .load_a(load_a), .load_b(load_b),
    .din_a(din_a), .din_b(din_b), .reg_a(reg_a), .reg_b(reg_b)
  );

  function automatic logic ref_bit(input logic [2:0] f, input logic a, input logic b);
    logic r;
    case (f[1:0])
      2'b00:   r = a & b;
      2'b01:   r = a | b;
      2'b10:   r = a ^ b;
      default: r = 1'b1;
    endcase
    return r ^ f[2];
  endfunction

  function automatic logic [W-1:0] ref_vec(input logic [2:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = ref_bit(f, a[i], b[i]);
    return r;
  endfunction

  // register contents after k right shifts with bits inb entering at the top
  function automatic logic [W-1:0] ref_shift(input logic [W-1:0] orig, input logic [W-1:0] inb, input int k);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      if (i < W - k) r[i] = orig[i + k];
      else           r[i] = inb[i - (W - k)];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
    load_a = 1'b1; load_b = 1'b1; din_a = a; din_b = b;
    @(posedge clk); @(negedge clk);
    load_a = 1'b0; load_b = 1'b0;
    check("R2 load A", reg_a, a);
    check("R2 load B", reg_b, b);
  endtask

  task automatic run_op(input logic [2:0] f, input logic [1:0] rt, input bit jam);
    logic [W-1:0] a0, b0, res, ina, inb;
    a0  = reg_a;
    b0  = reg_b;
    res = ref_vec(f, a0, b0);
    case (rt)
      2'b00:   begin ina = a0;  inb = b0;  end
      2'b01:   begin ina = res; inb = b0;  end
      2'b10:   begin ina = a0;  inb = res; end
      default: begin ina = b0;  inb = a0;  end
    endcase
    func_sel = f; route_sel = rt; exec_req = 1'b1;
    if (jam) begin
      load_a = 1'b1; load_b = 1'b1;
      din_a = W'($urandom); din_b = W'($urandom);
    end
    @(posedge clk); @(negedge clk);
    check("R8 first shift A", reg_a, ref_shift(a0, ina, 1));
    check("R8 first shift B", reg_b, ref_shift(b0, inb, 1));
    repeat (W - 1) @(posedge clk);
    @(negedge clk);
    load_a = 1'b0; load_b = 1'b0;
    check(jam ? "R7 R5 R6 result A" : "R5 R6 result A", reg_a, ref_shift(a0, ina, W));
    check(jam ? "R7 R5 R6 result B" : "R5 R6 result B", reg_b, ref_shift(b0, inb, W));
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R4 hold A", reg_a, ref_shift(a0, ina, W));
    check("R4 hold B", reg_b, ref_shift(b0, inb, W));
    exec_req = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd385));
    rst = 1'b1; exec_req = 1'b0; func_sel = '0; route_sel = '0;
    load_a = 1'b0; load_b = 1'b0; din_a = '1; din_b = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset A", reg_a, '0);
    check("R1 reset B", reg_b, '0);

    // R5: every function code, result routed into A
    for (int f = 0; f < 8; f++) begin
      do_load(4'b1100, 4'b1010);
      run_op(3'(f), 2'b01, 1'b0);
    end

    // R6: every route
    for (int r = 0; r < 4; r++) begin
      do_load(4'b0110, 4'b1011);
      run_op(3'b010, 2'(r), 1'b0);
    end

    // R7: loads held through a whole run
    do_load(4'b1001, 4'b0111);
    run_op(3'b001, 2'b10, 1'b1);

    // R9: load while holding after a run, then R4 re-press after release
    do_load(4'b0011, 4'b0101);
    exec_req = 1'b1; route_sel = 2'b11; func_sel = 3'b000;
    repeat (W) @(posedge clk);
    @(negedge clk);
    check("R9 swap done A", reg_a, 4'b0101);
    load_a = 1'b1; din_a = 4'b1110; load_b = 1'b1; din_b = 4'b0001;
    @(posedge clk); @(negedge clk);
    load_a = 1'b0; load_b = 1'b0;
    check("R9 load in hold A", reg_a, 4'b1110);
    check("R9 load in hold B", reg_b, 4'b0001);
    exec_req = 1'b0;
    @(posedge clk); @(negedge clk);
    run_op(3'b000, 2'b11, 1'b0);
    check("R4 second press A", reg_a, 4'b0001);

    // random mix
    for (int n = 0; n < 40; n++) begin
      do_load(W'($urandom), W'($urandom));
      run_op(3'($urandom), 2'($urandom), 1'($urandom));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule